// File: doc/BRIEF.md
# Double-Buffered Crosspoint Selection Stage

This block is the active half of a crosspoint switch. For each output lane it holds an active selection entry and drives the lane from one of the data inputs or from a shared advertise input. Staged entries arrive in parallel from a configuration register file outside the block. The active entries change only when the host allows it, so traffic keeps flowing while the next configuration is prepared.

An active-low commit strobe copies every staged entry into the active bank on a clock edge. Any set of outputs therefore switches in the same cycle. If the strobe is held low, the bank reloads on every clock, and each staged write shows up at the outputs one cycle later (transparent mode). A broadcast pulse writes one index and override value into every active entry at once, with no strobe needed. Reset points every output at the advertise input, and each output keeps that source until it is reconfigured. The data path is a purely combinational selector on single-bit lanes.

Top module: `xps_select_stage`

## Requirements
- R1: Each output `o` has a 6-bit active entry. Its 5-bit input index comes from `stage_idx[o*5 +: 5]` and its override bit from `stage_ovr[o]`. Output `o` follows the entry for `o` only.
- R2: While `commit_n` is high and `bcast_pulse` is low at a rising clock edge, no active entry changes. Staged changes are not visible at `data_out`.
- R3: When `commit_n` is low at a rising clock edge, all staged entries are copied into the active bank. Every changed output switches after that same edge.
- R4: While `commit_n` is held low, each change to the staged entries reaches `data_out` after the next rising clock edge (transparent mode).
- R5: When `bcast_pulse` is high at a rising clock edge, every active entry becomes {`bcast_ovr`, `bcast_idx`}, whatever `commit_n` is. A broadcast wins over a simultaneous commit.
- R6: While `rst_n` is low, every output carries `adv_in`, asynchronously. After release, outputs keep that source until a commit or a broadcast loads them.
- R7: An output whose active override bit is 0 carries `data_in[index]` combinationally, with no clock delay.
- R8: An output whose active override bit is 1 carries `adv_in`, whatever its index says.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous active-low reset; selects the advertise source everywhere |
| commit_n | input | 1 | Active-low transfer strobe from staged to active entries |
| bcast_pulse | input | 1 | Loads the broadcast entry into every output on this edge |
| bcast_idx | input | 5 | Input index used by a broadcast |
| bcast_ovr | input | 1 | Override bit used by a broadcast |
| stage_idx | input | 160 | Staged input indices, 5 bits per output, output 0 lowest |
| stage_ovr | input | 32 | Staged override bits, one per output |
| data_in | input | 32 | Data input lanes |
| adv_in | input | 1 | Advertise input lane |
| data_out | output | 32 | Output lanes |

## Verification
The bench keeps staged changes waiting across several clocks with the strobe high. A design that leaks the shadow bank through early would change outputs before the commit edge. It pulses the strobe for exactly one edge and checks every lane right after it, so a bank that commits lanes one at a time, or a cycle late, shows lanes with the wrong source. It asserts a broadcast together with a low strobe and a different staged set; a design that gives the commit priority would show the staged sources instead of the broadcast one. It also asserts reset between clock edges and checks the outputs at once, which catches a reset that waits for the clock or leaves old selections in place.

// File: rtl/xps_pkg.sv
package xps_pkg;

   // Selector implementation variants for one output lane
   typedef enum logic [0:0] {
      XPS_MUX_INDEXED = 1'b0,
      XPS_MUX_ONEHOT  = 1'b1
   } xps_mux_e;

   // Kind of update applied to the active bank on a clock edge
   typedef enum logic [1:0] {
      XPS_LD_HOLD   = 2'd0,
      XPS_LD_COMMIT = 2'd1,
      XPS_LD_BCAST  = 2'd2
   } xps_load_e;

endpackage

// File: rtl/xps_load_ctrl.sv
module xps_load_ctrl
   import xps_pkg::*;
(
   input  logic      commit_n,
   input  logic      bcast_pulse,
   output xps_load_e load_kind
);

   // Broadcast has priority over the transfer strobe
   always_comb begin
      if (bcast_pulse)
         load_kind = XPS_LD_BCAST;
      else if (!commit_n)
         load_kind = XPS_LD_COMMIT;
      else
         load_kind = XPS_LD_HOLD;
   end

endmodule

// File: rtl/xps_active_bank.sv
module xps_active_bank
   import xps_pkg::*;
#(
   parameter int N_OUT = 32,
   parameter int IDX_W = 5
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  xps_load_e              load_kind,
   input  logic [N_OUT*IDX_W-1:0] stage_idx,
   input  logic [N_OUT-1:0]       stage_ovr,
   input  logic [IDX_W-1:0]       bcast_idx,
   input  logic                   bcast_ovr,
   output logic [N_OUT*IDX_W-1:0] act_idx,
   output logic [N_OUT-1:0]       act_ovr
);

   generate
      if (N_OUT < 1) begin : g_bad_nout
         $error("xps_active_bank: N_OUT must be at least 1");
      end
      if (IDX_W < 1) begin : g_bad_idxw
         $error("xps_active_bank: IDX_W must be at least 1");
      end
   endgenerate

   genvar o;
   generate
      for (o = 0; o < N_OUT; o++) begin : g_entry
         logic [IDX_W-1:0] idx_q;
         logic             ovr_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               idx_q <= '0;
               ovr_q <= 1'b1;
            end else begin
               unique case (load_kind)
                  XPS_LD_BCAST: begin
                     idx_q <= bcast_idx;
                     ovr_q <= bcast_ovr;
                  end
                  XPS_LD_COMMIT: begin
                     idx_q <= stage_idx[o*IDX_W +: IDX_W];
                     ovr_q <= stage_ovr[o];
                  end
                  default: begin
                     idx_q <= idx_q;
                     ovr_q <= ovr_q;
                  end
               endcase
            end
         end

         assign act_idx[o*IDX_W +: IDX_W] = idx_q;
         assign act_ovr[o]                = ovr_q;
      end
   endgenerate

endmodule

// File: rtl/xps_lane_mux.sv
module xps_lane_mux
   import xps_pkg::*;
#(
   parameter int       N_IN      = 32,
   parameter int       IDX_W     = 5,
   parameter xps_mux_e MUX_STYLE = XPS_MUX_INDEXED
) (
   input  logic [N_IN-1:0]  data_in,
   input  logic             adv_in,
   input  logic [IDX_W-1:0] sel_idx,
   input  logic             sel_ovr,
   output logic             lane_out
);

   logic picked;

   generate
      if (N_IN > (1 << IDX_W)) begin : g_bad_width
         $error("xps_lane_mux: IDX_W too narrow for N_IN");
      end

      if (MUX_STYLE == XPS_MUX_INDEXED) begin : g_indexed
         always_comb begin
            picked = 1'b0;
            if (int'(sel_idx) < N_IN)
               picked = data_in[sel_idx];
         end
      end else begin : g_onehot
         logic [N_IN-1:0] hot;
         genvar k;
         for (k = 0; k < N_IN; k++) begin : g_dec
            assign hot[k] = (sel_idx == IDX_W'(k));
         end
         assign picked = |(hot & data_in);
      end
   endgenerate

   assign lane_out = sel_ovr ? adv_in : picked;

endmodule

// File: rtl/xps_select_stage.sv
module xps_select_stage
   import xps_pkg::*;
#(
   parameter int       N_IN      = 32,
   parameter int       N_OUT     = 32,
   parameter xps_mux_e MUX_STYLE = XPS_MUX_INDEXED,
   localparam int      IDX_W     = (N_IN > 1) ? $clog2(N_IN) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   commit_n,
   input  logic                   bcast_pulse,
   input  logic [IDX_W-1:0]       bcast_idx,
   input  logic                   bcast_ovr,
   input  logic [N_OUT*IDX_W-1:0] stage_idx,
   input  logic [N_OUT-1:0]       stage_ovr,
   input  logic [N_IN-1:0]        data_in,
   input  logic                   adv_in,
   output logic [N_OUT-1:0]       data_out
);

   generate
      if (N_IN < 2) begin : g_bad_nin
         $error("xps_select_stage: N_IN must be at least 2");
      end
      if (N_OUT < 1) begin : g_bad_nout
         $error("xps_select_stage: N_OUT must be at least 1");
      end
   endgenerate

   xps_load_e              load_kind;
   logic [N_OUT*IDX_W-1:0] act_idx;
   logic [N_OUT-1:0]       act_ovr;

   xps_load_ctrl u_load_ctrl (
      .commit_n    (commit_n),
      .bcast_pulse (bcast_pulse),
      .load_kind   (load_kind)
   );

   xps_active_bank #(
      .N_OUT (N_OUT),
      .IDX_W (IDX_W)
   ) u_active_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_kind (load_kind),
      .stage_idx (stage_idx),
      .stage_ovr (stage_ovr),
      .bcast_idx (bcast_idx),
      .bcast_ovr (bcast_ovr),
      .act_idx   (act_idx),
      .act_ovr   (act_ovr)
   );

   genvar o;
   generate
      for (o = 0; o < N_OUT; o++) begin : g_lane
         xps_lane_mux #(
            .N_IN      (N_IN),
            .IDX_W     (IDX_W),
            .MUX_STYLE (MUX_STYLE)
         ) u_lane_mux (
            .data_in  (data_in),
            .adv_in   (adv_in),
            .sel_idx  (act_idx[o*IDX_W +: IDX_W]),
            .sel_ovr  (act_ovr[o]),
            .lane_out (data_out[o])
         );
      end
   endgenerate

endmodule

// File: rtl/xps_select_stage_chk.sv
module xps_select_stage_chk #(
   parameter int N_IN  = 32,
   parameter int N_OUT = 32,
   parameter int IDX_W = 5
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   commit_n,
   input logic                   bcast_pulse,
   input logic [IDX_W-1:0]       bcast_idx,
   input logic                   bcast_ovr,
   input logic [N_OUT*IDX_W-1:0] stage_idx,
   input logic [N_OUT-1:0]       stage_ovr,
   input logic [N_IN-1:0]        data_in,
   input logic                   adv_in,
   input logic [N_OUT-1:0]       data_out,
   input logic [N_OUT*IDX_W-1:0] act_idx,
   input logic [N_OUT-1:0]       act_ovr
);

   logic [N_OUT*IDX_W-1:0] bcast_rep;
   logic [N_OUT-1:0]       pass_ref;

   always_comb begin
      for (int o = 0; o < N_OUT; o++) begin
         bcast_rep[o*IDX_W +: IDX_W] = bcast_idx;
         pass_ref[o] = (int'(act_idx[o*IDX_W +: IDX_W]) < N_IN)
                       ? data_in[act_idx[o*IDX_W +: IDX_W]] : 1'b0;
      end
   end

   // R2: no load request, no change
   a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_n && !bcast_pulse) |=> ($stable(act_idx) && $stable(act_ovr)));

   // R3 and R4: a low strobe copies the whole staged set
   a_r3_commit_copies_all: assert property (@(posedge clk) disable iff (!rst_n)
      (!commit_n && !bcast_pulse) |=>
      (act_idx == $past(stage_idx) && act_ovr == $past(stage_ovr)));

   // R5: broadcast fills every entry and beats the strobe
   a_r5_broadcast_fills_all: assert property (@(posedge clk) disable iff (!rst_n)
      bcast_pulse |=>
      (act_idx == $past(bcast_rep) && act_ovr == {N_OUT{$past(bcast_ovr)}}));

   // R6: the first edge after reset release still sees every lane overridden
   a_r6_reset_selects_adv: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (&act_ovr));

   // R8: overridden lanes follow the advertise input
   a_r8_override_lanes: assert property (@(posedge clk) disable iff (!rst_n)
      ((data_out ^ {N_OUT{adv_in}}) & act_ovr) == '0);

   // R7: other lanes follow their selected input
   a_r7_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
      ((data_out ^ pass_ref) & ~act_ovr) == '0);

endmodule

bind xps_select_stage xps_select_stage_chk #(
   .N_IN  (N_IN),
   .N_OUT (N_OUT),
   .IDX_W (IDX_W)
) u_chk (.*);

// File: tb/xps_select_stage_bench.sv
module xps_select_stage_bench;

   localparam int CLK_PERIOD = 10;
   localparam int N  = 32;
   localparam int IW = 5;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            commit_n = 1'b1;
   logic            bcast_pulse = 1'b0;
   logic [IW-1:0]   bcast_idx = '0;
   logic            bcast_ovr = 1'b0;
   logic [N*IW-1:0] stage_idx = '0;
   logic [N-1:0]    stage_ovr = '0;
   logic [N-1:0]    data_in = '0;
   logic            adv_in = 1'b0;
   logic [N-1:0]    data_out;

   int    checks = 0;
   int    errors = 0;
   bit    done = 1'b0;
   string cur_req = "R6";

   int m_idx [N];
   bit m_ovr [N];

   xps_select_stage u_xps_select_stage (
      .clk         (clk),
      .rst_n       (rst_n),
      .commit_n    (commit_n),
      .bcast_pulse (bcast_pulse),
      .bcast_idx   (bcast_idx),
      .bcast_ovr   (bcast_ovr),
      .stage_idx   (stage_idx),
      .stage_ovr   (stage_ovr),
      .data_in     (data_in),
      .adv_in      (adv_in),
      .data_out    (data_out)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // Behavioural reference of the active selection
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int o = 0; o < N; o++) begin m_idx[o] = 0; m_ovr[o] = 1'b1; end
      end else if (bcast_pulse) begin
         for (int o = 0; o < N; o++) begin m_idx[o] = int'(bcast_idx); m_ovr[o] = bcast_ovr; end
      end else if (!commit_n) begin
         for (int o = 0; o < N; o++) begin
            m_idx[o] = int'(stage_idx[o*IW +: IW]);
            m_ovr[o] = stage_ovr[o];
         end
      end
   end

   // Fresh random traffic on every cycle
   always @(posedge clk) begin
      #2;
      data_in = $urandom;
      adv_in  = 1'($urandom % 2);
   end

   function automatic logic [N-1:0] expect_out();
      logic [N-1:0] e;
      for (int o = 0; o < N; o++)
         e[o] = m_ovr[o] ? adv_in : data_in[m_idx[o]];
      return e;
   endfunction

   task automatic check(string req, logic [N-1:0] act, logic [N-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s at %0t: data_out=%h expected=%h", req, $time, act, exp);
      end
   endtask

   // Compare against the model in the middle of every cycle
   always @(negedge clk) begin
      if (!done) check(cur_req, data_out, expect_out());
   end

   task automatic edges(int n);
      repeat (n) @(posedge clk);
      #3;
   endtask

   task automatic stage_random(bit ovr_rand);
      for (int o = 0; o < N; o++) begin
         stage_idx[o*IW +: IW] = IW'($urandom);
         stage_ovr[o] = ovr_rand ? 1'($urandom % 2) : 1'b0;
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      // R6: reset state and holding after release
      cur_req = "R6";
      edges(3);
      check("R6", data_out, {N{adv_in}});
      rst_n = 1'b1;
      stage_random(1'b0);
      edges(4);
      check("R6", data_out, {N{adv_in}});

      // R2: staged changes stay hidden while the strobe is high
      cur_req = "R2";
      stage_random(1'b0);
      edges(4);

      // R3: single-edge commit switches every lane together
      cur_req = "R3";
      commit_n = 1'b0;
      edges(1);
      commit_n = 1'b1;
      stage_random(1'b1);
      edges(3);

      // R1: per-output field positions, reversed mapping
      cur_req = "R1";
      for (int o = 0; o < N; o++) begin
         stage_idx[o*IW +: IW] = IW'(N - 1 - o);
         stage_ovr[o] = 1'b0;
      end
      commit_n = 1'b0;
      edges(1);
      commit_n = 1'b1;
      edges(3);

      // R8: override on even lanes, random indices elsewhere
      cur_req = "R8";
      stage_random(1'b0);
      for (int o = 0; o < N; o += 2) stage_ovr[o] = 1'b1;
      commit_n = 1'b0;
      edges(1);
      commit_n = 1'b1;
      edges(3);

      // R4: transparent mode, staged set changes every cycle
      cur_req = "R4";
      commit_n = 1'b0;
      for (int c = 0; c < 8; c++) begin
         stage_random(1'b1);
         edges(1);
      end
      commit_n = 1'b1;
      edges(2);

      // R5: broadcast without strobe, then broadcast against a commit
      cur_req = "R5";
      bcast_idx = 5'd7; bcast_ovr = 1'b0; bcast_pulse = 1'b1;
      edges(1);
      bcast_pulse = 1'b0;
      edges(2);
      stage_random(1'b0);
      commit_n = 1'b0;
      bcast_idx = 5'd31; bcast_ovr = 1'b0; bcast_pulse = 1'b1;
      edges(1);
      bcast_pulse = 1'b0; commit_n = 1'b1;
      edges(2);
      bcast_ovr = 1'b1; bcast_pulse = 1'b1;
      edges(1);
      bcast_pulse = 1'b0;
      edges(2);

      // R7: random mix of commits and broadcasts
      cur_req = "R7";
      for (int c = 0; c < 80; c++) begin
         stage_random(1'b1);
         commit_n    = 1'($urandom % 3 != 0);
         bcast_pulse = 1'($urandom % 9 == 0);
         bcast_idx   = IW'($urandom);
         bcast_ovr   = 1'($urandom % 4 == 0);
         edges(1);
      end
      commit_n = 1'b1; bcast_pulse = 1'b0;
      edges(2);

      // R6: reset asserted between edges takes effect at once
      cur_req = "R6";
      rst_n = 1'b0;
      #1;
      check("R6", data_out, {N{adv_in}});
      edges(2);
      rst_n = 1'b1;
      stage_random(1'b0);
      edges(3);
      check("R6", data_out, {N{adv_in}});

      finish_run();
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run hung, actual=timeout expected=completion");
         finish_run();
      end
   end

endmodule